// File: doc/BRIEF.md
# ECC Error Logging Status Unit

This unit watches the read side of an ECC-protected on-chip RAM. The decoder reports each read with a valid strobe, the word address and two result flags, correctable and uncorrectable. For every valid read that raises either flag, the unit stores the word address and the flag pair as one entry. Entries go into a queue of up to `DEPTH` entries, and the oldest entry is presented first. Software reads the queue through a small 32-bit register port, one word per register index. It removes the oldest entry by setting a self-clearing pop bit.

The same register port holds the write-path controls. An encoder-bypass enable and a parity byte leave the unit as plain pins and go to the RAM write path. A self-clearing soft-reset bit empties the queue, clears the overflow flag and clears the parity byte over a fixed window of cycles.

The error input has no ready signal, because RAM reads cannot be stalled. When the queue is full, the unit records the loss in a sticky overflow flag instead of applying back-pressure. The register port needs no handshake: reads are combinational from the index, and writes take effect at the clock edge where `reg_wr_en` is high.

Top module: `ecc_err_log`

## Requirements
- R1: An entry is stored only when `rd_valid` is high and at least one of `rd_corr` / `rd_uncorr` is high at a clock edge. The stored count rises by one after that edge.
- R2: The address register (index 1) shows the oldest entry's word address in bits [25:0], with bits [31:26] zero. The status register (index 2) shows the oldest entry's uncorrectable flag in bit 16 and its correctable flag in bit 0, with every other bit zero. Both registers read as zero while the queue is empty.
- R3: The level register (index 0) shows the stored count in bits [8:0]. With 512 entries stored, that field reads 0. Bits [30:9] read as zero.
- R4: An error arriving while 512 entries are stored, with no pop in that cycle, is discarded. It sets the overflow flag, bit 31 of the level register. The flag then stays set until it is cleared.
- R5: A register write to index 0 with bit 31 set clears the overflow flag. If an overflowing error arrives in the same cycle as that write, the flag stays set.
- R6: A register write to index 3 (control) with bit 1 set raises the pop bit. At the next edge, the oldest entry is removed and the pop bit returns to 0. Entries leave in arrival order.
- R7: A pop on an empty queue has no effect: the count stays 0 and the pop bit still returns to 0.
- R8: When an entry is stored and another removed at the same edge, both take place and the count is unchanged. This includes the case of a full queue.
- R9: A control write with bit 0 set makes control bit 0 read 1 for exactly 8 cycles. During that window the queue is emptied and the overflow flag and parity byte are cleared. Errors and parity writes in the window are discarded. Bit 0 then reads 0.
- R10: Control bit 2 (reset 0) drives `enc_bypass`. The parity register (index 4, bits [7:0], reset 0) drives `bypass_parity`. Both follow a write one cycle later, and soft reset does not change bit 2.
- R11: Register indices 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | RAM read result valid |
| rd_addr | input | 26 | Word address of the read |
| rd_corr | input | 1 | Correctable error on this read |
| rd_uncorr | input | 1 | Uncorrectable error on this read |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| enc_bypass | output | 1 | Encoder bypass enable to RAM write path |
| bypass_parity | output | 8 | Parity byte used while bypass is enabled |

## Verification
**Level, head and overflow.** An error sampled at edge N shows up in the level, head and overflow fields just after edge N.

**Pop.** A pop write at edge N raises control bit 1 after N. The entry leaves at edge N+1.

**Soft reset.** A soft-reset write at edge N holds control bit 0 high from N to N+8, and the clearing is done at each edge in that window.

**How the bench keeps to this.** The bench drives inputs and samples registers on the falling clock edge. Its model advances once per rising edge using the inputs that edge saw, so every comparison lands half a cycle after the edge that should have changed the value.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    SEL_LEVEL = 3'd0,
    SEL_ADDR  = 3'd1,
    SEL_STAT  = 3'd2,
    SEL_CTRL  = 3'd3,
    SEL_PAR   = 3'd4
  } reg_sel_e;

  localparam int CTL_SRST = 0;
  localparam int CTL_POP  = 1;
  localparam int CTL_BYP  = 2;
  localparam int OVF_BIT  = 31;
  localparam int UNC_BIT  = 16;
  localparam int COR_BIT  = 0;

  typedef struct packed {
    logic unc;
    logic cor;
  } ecc_flags_t;
endpackage

// File: rtl/ecc_log_intake.sv
module ecc_log_intake (
  input  logic rd_valid,
  input  logic rd_corr,
  input  logic rd_uncorr,
  input  logic clr,
  input  logic pop_req,
  input  logic full,
  input  logic empty,
  output logic push_ok,
  output logic pop_do,
  output logic ovf_set
);
  logic push_req;

  always_comb begin
    push_req = rd_valid & (rd_corr | rd_uncorr) & ~clr;
    pop_do   = pop_req & ~empty & ~clr;
    // a pop in the same cycle frees the slot the push needs
    push_ok  = push_req & (~full | pop_do);
    ovf_set  = push_req & ~push_ok;
  end
endmodule

// File: rtl/ecc_log_fifo.sv
module ecc_log_fifo #(
  parameter  int W     = 28,
  parameter  int DEPTH = 512,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam bit IS_POW2 = (DEPTH == (1 << PW));

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

  generate
    if (IS_POW2) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = empty ? '0 : mem[rd_ptr];
endmodule

// File: rtl/ecc_log_csr.sv
module ecc_log_csr
  import ecc_log_pkg::*;
#(
  parameter  int AW       = 26,
  parameter  int LW       = 9,
  parameter  int CW       = 10,
  parameter  int PAR_W    = 8,
  parameter  int SRST_LEN = 8,
  localparam int SCW      = $clog2(SRST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] sel,
  input  logic [31:0]       wdata,
  input  logic              ovf_set,
  input  logic [CW-1:0]     count,
  input  logic [AW-1:0]     head_addr,
  input  ecc_flags_t        head_flags,
  output logic [31:0]       rdata,
  output logic              pop_req,
  output logic              clr,
  output logic              ovf_flag,
  output logic              bypass,
  output logic [PAR_W-1:0]  parity
);
  logic [SCW-1:0] srst_cnt;
  logic wr_ctrl, wr_lvl, wr_par;
  logic unused_bits;

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_lvl  = wr_en && (sel == SEL_LEVEL);
  assign wr_par  = wr_en && (sel == SEL_PAR);
  assign clr     = (srst_cnt != '0);
  assign unused_bits = ^{wdata, count};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_cnt <= '0;
      pop_req  <= 1'b0;
      bypass   <= 1'b0;
    end else begin
      if (wr_ctrl && wdata[CTL_SRST]) srst_cnt <= SCW'(SRST_LEN);
      else if (clr)                   srst_cnt <= srst_cnt - 1'b1;
      pop_req <= wr_ctrl && wdata[CTL_POP];
      if (wr_ctrl) bypass <= wdata[CTL_BYP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      parity   <= '0;
    end else if (clr) begin
      ovf_flag <= 1'b0;
      parity   <= '0;
    end else begin
      if (ovf_set)                     ovf_flag <= 1'b1;
      else if (wr_lvl && wdata[OVF_BIT]) ovf_flag <= 1'b0;
      if (wr_par) parity <= wdata[PAR_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_LEVEL: begin
        rdata[OVF_BIT] = ovf_flag;
        rdata[LW-1:0]  = count[LW-1:0];
      end
      SEL_ADDR: rdata[AW-1:0] = head_addr;
      SEL_STAT: begin
        rdata[UNC_BIT] = head_flags.unc;
        rdata[COR_BIT] = head_flags.cor;
      end
      SEL_CTRL: begin
        rdata[CTL_SRST] = clr;
        rdata[CTL_POP]  = pop_req;
        rdata[CTL_BYP]  = bypass;
      end
      SEL_PAR: rdata[PAR_W-1:0] = parity;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter  int DEPTH    = 512,
  parameter  int RAM_AW   = 26,
  parameter  int PAR_W    = 8,
  parameter  int SRST_LEN = 8,
  localparam int LW       = $clog2(DEPTH),
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int EW       = RAM_AW + $bits(ecc_flags_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [RAM_AW-1:0] rd_addr,
  input  logic              rd_corr,
  input  logic              rd_uncorr,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              enc_bypass,
  output logic [PAR_W-1:0]  bypass_parity
);
  logic          push_ok, pop_do, ovf_set;
  logic          pop_req, clr, ovf_flag;
  logic          full, empty;
  logic [CW-1:0] count;
  logic [EW-1:0] entry_in, head;
  ecc_flags_t    in_flags, head_flags;
  logic [RAM_AW-1:0] head_addr;

  assign in_flags   = '{unc: rd_uncorr, cor: rd_corr};
  assign entry_in   = {in_flags, rd_addr};
  assign head_flags = ecc_flags_t'(head[EW-1:RAM_AW]);
  assign head_addr  = head[RAM_AW-1:0];

  ecc_log_intake u_intake (
    .rd_valid (rd_valid),
    .rd_corr  (rd_corr),
    .rd_uncorr(rd_uncorr),
    .clr      (clr),
    .pop_req  (pop_req),
    .full     (full),
    .empty    (empty),
    .push_ok  (push_ok),
    .pop_do   (pop_do),
    .ovf_set  (ovf_set)
  );

  ecc_log_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (clr),
    .push (push_ok),
    .pop  (pop_do),
    .din  (entry_in),
    .head (head),
    .count(count),
    .full (full),
    .empty(empty)
  );

  ecc_log_csr #(
    .AW(RAM_AW), .LW(LW), .CW(CW), .PAR_W(PAR_W), .SRST_LEN(SRST_LEN)
  ) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .sel       (reg_addr),
    .wdata     (reg_wdata),
    .ovf_set   (ovf_set),
    .count     (count),
    .head_addr (head_addr),
    .head_flags(head_flags),
    .rdata     (reg_rdata),
    .pop_req   (pop_req),
    .clr       (clr),
    .ovf_flag  (ovf_flag),
    .bypass    (enc_bypass),
    .parity    (bypass_parity)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk
  import ecc_log_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int CW    = 10,
  parameter int EW    = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_valid,
  input logic              rd_corr,
  input logic              rd_uncorr,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              enc_bypass,
  input logic [CW-1:0]     count,
  input logic              full,
  input logic              empty,
  input logic              push_ok,
  input logic              pop_do,
  input logic              pop_req,
  input logic              clr,
  input logic              ovf_flag,
  input logic [EW-1:0]     head
);
  logic err_in, ovf_clr_wr, pop_wr, ctrl_wr;
  assign err_in     = rd_valid && (rd_corr || rd_uncorr);
  assign ovf_clr_wr = reg_wr_en && (reg_addr == SEL_LEVEL) && reg_wdata[OVF_BIT];
  assign ctrl_wr    = reg_wr_en && (reg_addr == SEL_CTRL);
  assign pop_wr     = ctrl_wr && reg_wdata[CTL_POP];

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R2
  head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> head == '0);

  // R4
  ovf_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in && full && !pop_req && !clr) |=> ovf_flag);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr && !ovf_clr_wr) |=> ovf_flag);

  // R5
  ovf_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_wr && err_in && full && !pop_req && !clr) |=> ovf_flag);

  // R6
  pop_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !pop_wr) |=> !pop_req);

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req && !err_in) |=> empty);

  // R8
  pushpop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_do && !clr) |=> $stable(count));

  // R9
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0) && !ovf_flag);

  // R10
  bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> enc_bypass == $past(reg_wdata[CTL_BYP]));
endmodule

bind ecc_err_log ecc_err_log_chk #(.DEPTH(DEPTH), .CW(CW), .EW(EW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid),
  .rd_corr   (rd_corr),
  .rd_uncorr (rd_uncorr),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .enc_bypass(enc_bypass),
  .count     (count),
  .full      (full),
  .empty     (empty),
  .push_ok   (push_ok),
  .pop_do    (pop_do),
  .pop_req   (pop_req),
  .clr       (clr),
  .ovf_flag  (ovf_flag),
  .head      (head)
);

// File: tb/sim_ecc_err_log.sv
module sim_ecc_err_log;
  localparam int DEPTH = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [25:0] rd_addr = '0;
  logic        rd_corr = 1'b0;
  logic        rd_uncorr = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        enc_bypass;
  logic [7:0]  bypass_parity;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [27:0] mq[$];
  bit          m_ovf = 0, m_pop = 0, m_byp = 0;
  int          m_srst = 0;
  logic [7:0]  m_par = '0;

  always #10 clk = ~clk;

  ecc_err_log u0 (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_corr(rd_corr), .rd_uncorr(rd_uncorr), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .enc_bypass(enc_bypass), .bypass_parity(bypass_parity)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_level();
    logic [31:0] v = '0;
    int sz = mq.size();
    v[31] = m_ovf;
    v[8:0] = sz[8:0];
    return v;
  endfunction

  function automatic logic [31:0] exp_addr();
    if (mq.size() == 0) return '0;
    return {6'd0, mq[0][25:0]};
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] v = '0;
    if (mq.size() == 0) return v;
    v[16] = mq[0][27];
    v[0]  = mq[0][26];
    return v;
  endfunction

  function automatic logic [31:0] exp_ctrl();
    return {29'd0, m_byp, m_pop, (m_srst != 0)};
  endfunction

  task automatic rd_reg(input logic [2:0] idx, output logic [31:0] v);
    reg_addr = idx;
    #1 v = reg_rdata;
  endtask

  task automatic check_state();
    logic [31:0] v;
    rd_reg(3'd0, v); chk("R3 level", v, exp_level());
    rd_reg(3'd1, v); chk("R2 addr head", v, exp_addr());
    rd_reg(3'd2, v); chk("R2 status head", v, exp_stat());
    rd_reg(3'd3, v); chk("R9 control", v, exp_ctrl());
    rd_reg(3'd4, v); chk("R10 parity reg", v, {24'd0, m_par});
    chk("R10 enc_bypass", {31'd0, enc_bypass}, {31'd0, m_byp});
    chk("R10 bypass_parity", {24'd0, bypass_parity}, {24'd0, m_par});
  endtask

  // one clock: drive at falling edge, model at rising edge, check after
  task automatic step(bit v, logic [25:0] a, bit c, bit u,
                      bit we, logic [2:0] ra, logic [31:0] wd);
    bit srst_act, pop_do, push_req, push_ok;
    rd_valid = v; rd_addr = a; rd_corr = c; rd_uncorr = u;
    reg_wr_en = we; reg_addr = ra; reg_wdata = wd;
    @(posedge clk);
    srst_act = (m_srst != 0);
    pop_do   = m_pop && (mq.size() > 0) && !srst_act;
    push_req = v && (c || u) && !srst_act;
    push_ok  = push_req && ((mq.size() < DEPTH) || pop_do);
    if (srst_act) begin
      mq.delete(); m_ovf = 0; m_par = '0;
    end else begin
      if (pop_do) void'(mq.pop_front());
      if (push_ok) mq.push_back({u, c, a});
      if (push_req && !push_ok) m_ovf = 1;
      else if (we && ra == 3'd0 && wd[31]) m_ovf = 0;
      if (we && ra == 3'd4) m_par = wd[7:0];
    end
    m_pop = we && ra == 3'd3 && wd[1];
    if (we && ra == 3'd3) m_byp = wd[2];
    if (we && ra == 3'd3 && wd[0]) m_srst = 8;
    else if (m_srst != 0) m_srst--;
    @(negedge clk);
    rd_valid = 0; rd_corr = 0; rd_uncorr = 0; reg_wr_en = 0;
    check_state();
  endtask

  task automatic idle(); step(0, '0, 0, 0, 0, 3'd0, '0); endtask
  task automatic err(logic [25:0] a, bit c, bit u); step(1, a, c, u, 0, 3'd0, '0); endtask
  task automatic wr(logic [2:0] ra, logic [31:0] wd); step(0, '0, 0, 0, 1, ra, wd); endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    check_state();                                   // reset state (R3, R9, R10)

    // R1: valid without flags, flags without valid
    step(1, 26'h123, 0, 0, 0, 3'd0, '0);
    step(0, 26'h124, 1, 1, 0, 3'd0, '0);
    chk("R1 no push", {31'd0, reg_rdata[0]}, 32'd0);

    // R1, R2: three entries, distinct flag patterns
    err(26'h3FFFFFF, 1, 0);
    err(26'h0000155, 0, 1);
    err(26'h2AAAAAA, 1, 1);

    // R6: pop ordering, control bit visible then cleared
    wr(3'd3, 32'h2);
    idle();
    idle();

    // R8: push and pop at the same edge
    wr(3'd3, 32'h2);
    err(26'h0BEEF, 0, 1);

    // R10: bypass and parity
    wr(3'd3, 32'h4);
    wr(3'd4, 32'hFFFF_FFA5);

    // R9: soft reset window, errors and parity writes dropped inside it
    wr(3'd3, 32'h5);
    err(26'h11, 1, 0);
    wr(3'd4, 32'h3C);
    for (int i = 0; i < 7; i++) idle();
    err(26'h22, 1, 0);

    // R7: pop on an empty queue
    wr(3'd3, 32'h1);
    for (int i = 0; i < 8; i++) idle();
    wr(3'd3, 32'h2);
    idle();

    // R11: unmapped indices
    wr(3'd6, 32'hFFFF_FFFF);
    for (int i = 5; i < 8; i++) begin
      rd_reg(3'(i), v); chk("R11 unmapped read", v, 32'd0);
    end

    // R3, R4, R5: fill, wrap, overflow
    for (int i = 0; i < DEPTH; i++) err(26'(i * 7 + 1), i[0], ~i[0]);
    rd_reg(3'd0, v); chk("R3 full wraps to 0", v, 32'd0);
    err(26'h777, 1, 0);
    rd_reg(3'd0, v); chk("R4 overflow set", v, 32'h8000_0000);
    step(1, 26'h778, 0, 1, 1, 3'd0, 32'h8000_0000);
    rd_reg(3'd0, v); chk("R5 new overflow wins", v, 32'h8000_0000);
    wr(3'd0, 32'h8000_0000);
    rd_reg(3'd0, v); chk("R5 cleared", v, 32'd0);
    wr(3'd3, 32'h2);
    err(26'h999, 1, 1);                               // R8 full push+pop
    rd_reg(3'd0, v); chk("R8 full push+pop no overflow", v, 32'd0);
    wr(3'd3, 32'h1);
    for (int i = 0; i < 8; i++) idle();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 20)       wr(3'd3, {29'd0, 1'($urandom), 1'b1, 1'b0});
      else if (r < 21)  wr(3'd3, {29'd0, 1'($urandom), 2'b01});
      else if (r < 24)  wr(3'd0, $urandom);
      else if (r < 26)  wr(3'd4, $urandom);
      else              step($urandom_range(0, 3) != 0, 26'($urandom),
                             1'($urandom), 1'($urandom), 0, 3'd0, '0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule